// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

The controller watches a set of device request lines and decides when the processor should break off the running program to serve one of them. Each device comes with a 3-bit priority level (0 to 7) and an 8-bit vector. Each request line is assumed to be already gated by that device's enable, so it is high only while the device is allowed to ask and actually needs service. The controller ranks the pending requests. A request wins only if its level is strictly above the processor's current level. The decision is made only in a cycle where the processor reports that an instruction has finished.

When it accepts a request, the controller sends the processor a one-cycle take pulse. It also presents the winner's vector, the winner's level (which becomes the new current level) and the handler-table address, which is 0x0100 plus the vector. The `in_service` output tells the processor to enter supervisor state. The controller then accepts nothing further until the processor returns a done acknowledge. Saving context, managing the supervisor stack, returning from the handler, reading the handler pointer from memory and the device registers all sit outside this block.

The sequencer has three states, WATCH, GRANT and HOLD. WATCH moves to GRANT on *accept*, which needs a finished instruction, a pending winner and a winner level above the current level. GRANT always moves to HOLD after one cycle (*issue*). HOLD moves back to WATCH when `ack_done` is high (*release*).

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `take_irq` and `in_service` are 0, and `irq_vec`, `irq_prio` and `tbl_addr` read 0.
- R2: No request is accepted in a cycle where `instr_done` is 0.
- R3: A request is accepted only if its level is strictly greater than `cur_prio`. An equal level is refused, and level 0 is never accepted.
- R4: The winner is the pending request with the highest level. Among requests of equal level, the lowest device index wins. Device i's level is `src_prio[3i+2:3i]` and its vector is `src_vec[8i+7:8i]`.
- R5: If the accept conditions hold at a clock edge, `take_irq` is high for exactly the following cycle. In that cycle `irq_vec` and `irq_prio` carry the winner's vector and level.
- R6: `tbl_addr` equals 0x0100 plus `irq_vec`, which spans 0x0100 to 0x01FF.
- R7: From the take cycle until the cycle after `ack_done` is seen in HOLD, no further request is accepted. `ack_done` has no effect while in WATCH.
- R8: `in_service` (supervisor entry) is high in the take cycle and stays high until the release.
- R9: With no request line high, nothing is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_SRC | Enable-gated request line per device |
| src_prio | input | N_SRC*PRIO_W | Packed per-device levels |
| src_vec | input | N_SRC*VEC_W | Packed per-device vectors |
| cur_prio | input | PRIO_W | Level of the running program |
| instr_done | input | 1 | Instruction-boundary strobe |
| ack_done | input | 1 | Processor has finished taking the interrupt |
| take_irq | output | 1 | One-cycle take pulse |
| in_service | output | 1 | Supervisor entry in progress |
| irq_vec | output | VEC_W | Winner's vector |
| irq_prio | output | PRIO_W | Winner's level, the new current level |
| tbl_addr | output | ADDR_W | Handler-table entry address |

## Verification
The bench builds the block with its defaults: four devices, 3-bit levels, 8-bit vectors and a 16-bit table address. Four devices keep the request patterns small enough for the bench to compute the winner arithmetically for every trial. The sweep cycles `cur_prio` through all eight levels and draws request, level and vector patterns from a shift-register sequence, so it produces equal-level ties, refusals at equal level and vectors across the full table range. Every accepted trial holds the requests and `instr_done` high through HOLD, which exercises the no-retake rule on each acceptance.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_GRANT = 2'd1,
        ST_HOLD  = 2'd2
    } irq_state_t;
endpackage

// File: rtl/irq_rank.sv
module irq_rank #(
    parameter int N_SRC  = 4,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC*VEC_W-1:0]  src_vec,
    output logic                    win_valid,
    output logic [PRIO_W-1:0]       win_prio,
    output logic [VEC_W-1:0]        win_vec
);
    // Linear scan; strict compare keeps the lower index on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_prio  = '0;
        win_vec   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (!win_valid || src_prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_valid = 1'b1;
                win_prio  = src_prio[i*PRIO_W +: PRIO_W];
                win_vec   = src_vec[i*VEC_W +: VEC_W];
            end
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [VEC_W-1:0]  cand_vec,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic              instr_done,
    input  logic              ack_done,
    output logic              take_irq,
    output logic              in_service,
    output logic [PRIO_W-1:0] irq_prio,
    output logic [VEC_W-1:0]  irq_vec
);
    irq_state_t state, state_nx;
    logic       accept;

    assign accept = instr_done && cand_valid && (cand_prio > cur_prio);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WATCH: if (accept)   state_nx = ST_GRANT;
            ST_GRANT:               state_nx = ST_HOLD;
            ST_HOLD:  if (ack_done) state_nx = ST_WATCH;
            default:                state_nx = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WATCH;
        else        state <= state_nx;
    end

    // Winner is captured on the accepting edge and held afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_prio <= '0;
            irq_vec  <= '0;
        end else if (state == ST_WATCH && accept) begin
            irq_prio <= cand_prio;
            irq_vec  <= cand_vec;
        end
    end

    always_comb begin
        take_irq   = 1'b0;
        in_service = 1'b0;
        unique case (state)
            ST_WATCH: ;
            ST_GRANT: begin
                take_irq   = 1'b1;
                in_service = 1'b1;
            end
            ST_HOLD:  in_service = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int             N_SRC    = 4,
    parameter int             PRIO_W   = 3,
    parameter int             VEC_W    = 8,
    parameter int             ADDR_W   = 16,
    parameter logic [15:0]    TBL_BASE = 16'h0100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_SRC*VEC_W-1:0]  src_vec,
    input  logic [PRIO_W-1:0]       cur_prio,
    input  logic                    instr_done,
    input  logic                    ack_done,
    output logic                    take_irq,
    output logic                    in_service,
    output logic [VEC_W-1:0]        irq_vec,
    output logic [PRIO_W-1:0]       irq_prio,
    output logic [ADDR_W-1:0]       tbl_addr
);
    localparam int PAD_W = ADDR_W - VEC_W;

    logic              win_valid;
    logic [PRIO_W-1:0] win_prio;
    logic [VEC_W-1:0]  win_vec;
    logic              active;

    irq_rank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_rank (
        .req       (req),
        .src_prio  (src_prio),
        .src_vec   (src_vec),
        .win_valid (win_valid),
        .win_prio  (win_prio),
        .win_vec   (win_vec)
    );

    irq_seq #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (win_valid),
        .cand_prio  (win_prio),
        .cand_vec   (win_vec),
        .cur_prio   (cur_prio),
        .instr_done (instr_done),
        .ack_done   (ack_done),
        .take_irq   (take_irq),
        .in_service (in_service),
        .irq_prio   (irq_prio),
        .irq_vec    (irq_vec)
    );

    // Address reads 0 out of reset, table entry once a vector is held.
    assign active   = (irq_vec != '0) || (irq_prio != '0);
    assign tbl_addr = active ? (ADDR_W'(TBL_BASE) + {{PAD_W{1'b0}}, irq_vec}) : '0;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
    parameter int PRIO_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PRIO_W-1:0] cur_prio,
    input logic              instr_done,
    input logic              ack_done,
    input logic              take_irq,
    input logic              in_service,
    input logic [PRIO_W-1:0] irq_prio
);
    // R5
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);
    // R2
    take_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> $past(instr_done));
    // R3
    take_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (irq_prio > $past(cur_prio)));
    // R7
    no_retake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(in_service));
    // R8
    super_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> in_service);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !take_irq && ack_done) |=> !in_service);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_prio   (cur_prio),
    .instr_done (instr_done),
    .ack_done   (ack_done),
    .take_irq   (take_irq),
    .in_service (in_service),
    .irq_prio   (irq_prio)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/100ps
module prio_irq_ctrl_test;
    localparam int NS = 4, PW = 3, VW = 8, AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    req = '0;
    logic [NS*PW-1:0] sp = '0;
    logic [NS*VW-1:0] sv = '0;
    logic [PW-1:0]    cur = '0;
    logic done = 1'b0, ack = 1'b0;
    logic take, insvc;
    logic [VW-1:0] vec;
    logic [PW-1:0] prio;
    logic [AW-1:0] addr;

    int n_chk = 0, n_bad = 0;
    logic [31:0] rs = 32'h1234_5678;

    always #2.5 clk = ~clk;

    prio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .src_prio(sp), .src_vec(sv),
        .cur_prio(cur), .instr_done(done), .ack_done(ack),
        .take_irq(take), .in_service(insvc), .irq_vec(vec), .irq_prio(prio),
        .tbl_addr(addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic trial(input logic [NS-1:0] r, input logic [NS*PW-1:0] p,
                         input logic [NS*VW-1:0] v, input logic [PW-1:0] c,
                         input logic d);
        int best, bp, bv;
        bit et;
        string tag;
        best = -1; bp = 0; bv = 0;
        for (int i = 0; i < NS; i++)
            if (r[i] && (best < 0 || int'(p[i*PW +: PW]) > bp)) begin
                best = i;
                bp = int'(p[i*PW +: PW]);
                bv = int'(v[i*VW +: VW]);
            end
        et = d && best >= 0 && bp > int'(c);
        if (best < 0) tag = "R9 no request";
        else if (!d)  tag = "R2 no boundary";
        else if (!et) tag = "R3 not above current";
        else          tag = "R5 take";
        req = r; sp = p; sv = v; cur = c; done = d; ack = 1'b0;
        @(negedge clk);
        chk(take == et, tag, int'(take), int'(et));
        if (et) begin
            chk(int'(prio) == bp, "R4 winner level", int'(prio), bp);
            chk(int'(vec) == bv, "R4/R5 winner vector", int'(vec), bv);
            chk(int'(addr) == 32'h100 + bv, "R6 table address", int'(addr), 32'h100 + bv);
            chk(insvc == 1'b1, "R8 supervisor entry", int'(insvc), 1);
            @(negedge clk);
            chk(take == 1'b0, "R5 single pulse", int'(take), 0);
            chk(insvc == 1'b1, "R8 held until ack", int'(insvc), 1);
            ack = 1'b1;
            @(negedge clk);
            chk(take == 1'b0, "R7 no retake while held", int'(take), 0);
            chk(insvc == 1'b0, "R7 release on ack", int'(insvc), 0);
            ack = 1'b0;
        end
        done = 1'b0;
        req = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(take == 0 && insvc == 0, "R1 reset strobes", int'({take, insvc}), 0);
        chk(vec == 0 && prio == 0 && addr == 0, "R1 reset values", int'(addr), 0);

        // R4 tie: devices 1 and 2 at level 5, device 1 wins
        trial(4'b0110, {3'd5, 3'd5, 3'd5, 3'd1}, {8'hD4, 8'hC3, 8'hB2, 8'hA1}, 3'd2, 1'b1);
        // R3 equal level refused
        trial(4'b0001, {3'd0, 3'd0, 3'd0, 3'd4}, {8'h0, 8'h0, 8'h0, 8'h77}, 3'd4, 1'b1);
        // R6 top vector
        trial(4'b1000, {3'd7, 3'd0, 3'd0, 3'd0}, {8'hFF, 8'h0, 8'h0, 8'h0}, 3'd0, 1'b1);

        // R7 ack while watching has no effect
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(insvc == 1'b0 && take == 1'b0, "R7 ack ignored in watch", int'(insvc), 0);
        trial(4'b0100, {3'd0, 3'd6, 3'd0, 3'd0}, {8'h0, 8'h5A, 8'h0, 8'h0}, 3'd3, 1'b1);

        // sweep: every current level against shifted-register patterns
        for (int t = 0; t < 2400; t++) begin
            logic [NS-1:0]    r;
            logic [NS*PW-1:0] p;
            logic [NS*VW-1:0] v;
            rs = nxt(rs); r = rs[NS-1:0]; p = rs[NS*PW+8-1:8];
            rs = nxt(rs); v = rs;
            trial(r, p, v, PW'(t % 8), (t % 5) != 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule